// File: doc/BRIEF.md
# Byte-Counting Phase Barrier

This block lets a consumer wait for an asynchronous transfer without a done flag that someone has to clear. A controller arms the barrier with the number of bytes the current round is expected to deliver. A data mover then reports delivered bytes in any number of chunks. When the running total reaches the armed count, the barrier toggles a one-bit phase, clears its total and disarms itself, ready to be armed again for the next round.

A waiter holds its own local phase bit and presents it on an input. It is released while that bit differs from the barrier phase. After it passes, it toggles its local bit, so it blocks again until the next round completes. A separate commit input completes a round with no byte accounting. A compute engine uses it to signal that an operation has finished.

Top module: `txn_phase_barrier`

## Requirements
- R1: After reset, `phase_o` is 0, `armed_o` is 0 and `ovf_o` is 0.
- R2: `release_o` is 1 exactly when `wait_phase_i` differs from `phase_o`. It is combinational from both.
- R3: A cycle with `arm_valid_i` high loads `arm_bytes_i` as the expected count and raises `armed_o` one cycle later, unless that same cycle also completes the round.
- R4: Each accepted report adds `rpt_bytes_i` to a running total. `phase_o` toggles in the cycle after the report that brings the total to the expected count, and not earlier.
- R5: When the phase toggles, the running total clears to zero and `armed_o` drops. Bytes from the finished round never count toward the next one.
- R6: A report that pushes the total past the expected count still toggles the phase. It also sets `ovf_o`, which stays 1 until reset.
- R7: `commit_i` toggles the phase one cycle later whether or not the barrier is armed. It also clears the total and disarms. A commit in the same cycle as a completing report toggles the phase only once.
- R8: When arming and a report occur in the same cycle, the arm is applied first and the report counts against the newly armed count.
- R9: A report while the barrier is unarmed (and no arm occurs that cycle) is ignored. The phase does not change and the bytes do not count toward a later round.
- R10: Arming while already armed replaces the expected count and keeps the bytes already accumulated.
- R11: The byte count is 20 bits wide (`CNT_W` = 20). The total is compared with one extra bit, so a sum beyond the 20-bit range counts as an overshoot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_valid_i | input | 1 | Arm the barrier for a round |
| arm_bytes_i | input | CNT_W | Expected byte count for the round |
| rpt_valid_i | input | 1 | Data mover byte report strobe |
| rpt_bytes_i | input | CNT_W | Bytes delivered in this report |
| commit_i | input | 1 | Plain arrive that completes the round |
| wait_phase_i | input | 1 | Waiter's local phase bit |
| phase_o | output | 1 | Barrier phase |
| release_o | output | 1 | Waiter may proceed |
| armed_o | output | 1 | An expected count is loaded for the current round |
| ovf_o | output | 1 | Sticky overshoot error |

## Verification
The assertions check on every cycle that:
- the phase moves only after a report or a commit;
- a commit always toggles the phase;
- every toggle leaves the barrier disarmed;
- the overflow flag never falls;
- a report to an unarmed barrier leaves the phase alone.

Only the bench's scenarios can show the byte arithmetic. This covers the exact cycle a multi-chunk round completes and the exclusion of stale bytes after a toggle. It also covers the same-cycle orderings of arm, report and commit, and the waiter's toggle-and-block sequence across consecutive rounds.

// File: rtl/txn_barrier_pkg.sv
package txn_barrier_pkg;
  localparam int unsigned CNT_W = 20;
  localparam int unsigned SUM_W = CNT_W + 1;
endpackage

// File: rtl/bar_arm_reg.sv
module bar_arm_reg #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_valid_i,
  input  logic [CNT_W-1:0] arm_bytes_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] expect_eff_o,
  output logic             armed_eff_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] expect_q;
  logic             armed_q;

  // arm applies before any same-cycle report
  assign expect_eff_o = arm_valid_i ? arm_bytes_i : expect_q;
  assign armed_eff_o  = arm_valid_i | armed_q;
  assign armed_o      = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expect_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (arm_valid_i) expect_q <= arm_bytes_i;
      if (done_i)           armed_q <= 1'b0;
      else if (arm_valid_i) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bar_byte_accum.sv
module bar_byte_accum #(
  parameter int unsigned CNT_W = 20,
  localparam int unsigned SUM_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rpt_valid_i,
  input  logic [CNT_W-1:0] rpt_bytes_i,
  input  logic             armed_eff_i,
  input  logic [CNT_W-1:0] expect_eff_i,
  input  logic             clr_i,
  output logic             hit_o,
  output logic             over_o
);
  logic [CNT_W-1:0] total_q;
  logic [SUM_W-1:0] sum;
  logic             accept;

  assign accept = rpt_valid_i & armed_eff_i;
  assign sum    = {1'b0, total_q} + {1'b0, rpt_bytes_i};
  assign hit_o  = accept & (sum >= {1'b0, expect_eff_i});
  assign over_o = accept & (sum >  {1'b0, expect_eff_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              total_q <= '0;
    else if (hit_o || clr_i)  total_q <= '0;
    else if (accept)          total_q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/bar_phase_reg.sv
module bar_phase_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  input  logic err_i,
  input  logic wait_phase_i,
  output logic phase_o,
  output logic release_o,
  output logic ovf_o
);
  logic phase_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (flip_i) phase_q <= ~phase_q;
      if (err_i)  ovf_q   <= 1'b1;
    end
  end

  assign phase_o   = phase_q;
  assign ovf_o     = ovf_q;
  assign release_o = wait_phase_i ^ phase_q;
endmodule

// File: rtl/txn_phase_barrier.sv
module txn_phase_barrier
  import txn_barrier_pkg::*;
#(
  parameter int unsigned CNT_W_P = CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_valid_i,
  input  logic [CNT_W_P-1:0] arm_bytes_i,
  input  logic               rpt_valid_i,
  input  logic [CNT_W_P-1:0] rpt_bytes_i,
  input  logic               commit_i,
  input  logic               wait_phase_i,
  output logic               phase_o,
  output logic               release_o,
  output logic               armed_o,
  output logic               ovf_o
);
  logic [CNT_W_P-1:0] expect_eff;
  logic armed_eff, hit, over, done;

  assign done = hit | commit_i;

  bar_arm_reg #(.CNT_W(CNT_W_P)) u_arm (
    .clk_i, .rst_ni, .arm_valid_i, .arm_bytes_i,
    .done_i(done), .expect_eff_o(expect_eff),
    .armed_eff_o(armed_eff), .armed_o
  );

  bar_byte_accum #(.CNT_W(CNT_W_P)) u_acc (
    .clk_i, .rst_ni, .rpt_valid_i, .rpt_bytes_i,
    .armed_eff_i(armed_eff), .expect_eff_i(expect_eff),
    .clr_i(commit_i), .hit_o(hit), .over_o(over)
  );

  bar_phase_reg u_ph (
    .clk_i, .rst_ni, .flip_i(done), .err_i(over),
    .wait_phase_i, .phase_o, .release_o, .ovf_o
  );
endmodule

// File: rtl/txn_phase_barrier_chk.sv
module txn_phase_barrier_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic arm_valid_i,
  input logic rpt_valid_i,
  input logic commit_i,
  input logic phase_o,
  input logic armed_o,
  input logic ovf_o
);
  // R4 / R7: phase moves only after a report or a commit
  a_r4_flip_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |-> $past(rpt_valid_i || commit_i));

  a_r7_commit_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (phase_o != $past(phase_o)));

  a_r5_disarm_on_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |-> !armed_o);

  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovf_o) |-> ovf_o);

  a_r9_unarmed_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && rpt_valid_i && !arm_valid_i && !commit_i) |=> $stable(phase_o));
endmodule

bind txn_phase_barrier txn_phase_barrier_chk u_chk (
  .clk_i, .rst_ni, .arm_valid_i, .rpt_valid_i, .commit_i,
  .phase_o, .armed_o, .ovf_o
);

// File: tb/tb_txn_phase_barrier.sv
module tb_txn_phase_barrier;
  localparam int unsigned W = 20;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm_v = 0, rpt_v = 0, com = 0, wph = 0;
  logic [W-1:0] arm_b = '0, rpt_b = '0;
  logic phase, rel, armed, ovf;

  int checks = 0, errors = 0;
  // bench model
  logic m_ph = 0, m_arm = 0, m_ovf = 0;
  logic [W-1:0] m_exp = '0;
  logic [W:0]   m_tot = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_phase_barrier dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_valid_i(arm_v), .arm_bytes_i(arm_b),
    .rpt_valid_i(rpt_v), .rpt_bytes_i(rpt_b), .commit_i(com),
    .wait_phase_i(wph), .phase_o(phase), .release_o(rel),
    .armed_o(armed), .ovf_o(ovf)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic [W-1:0] ab,
                     input logic r, input logic [W-1:0] rb, input logic c);
    logic ea, done;
    logic [W-1:0] ee;
    logic [W:0] s;
    arm_v = a; arm_b = ab; rpt_v = r; rpt_b = rb; com = c;
    ea = a | m_arm; ee = a ? ab : m_exp;
    s = m_tot + {1'b0, rb};
    done = c;
    if (r && ea) begin
      if (s >= {1'b0, ee}) done = 1;
      if (s >  {1'b0, ee}) m_ovf = 1;
    end
    if (a) m_exp = ab;
    if (done) begin m_tot = '0; m_arm = 0; m_ph = ~m_ph; end
    else begin
      if (a) m_arm = 1;
      if (r && ea) m_tot = s;
    end
    @(negedge clk);
    arm_v = 0; rpt_v = 0; com = 0;
    chk("R4 phase", phase, m_ph);
    chk("R3 armed", armed, m_arm);
    chk("R6 ovf", ovf, m_ovf);
    chk("R2 release", rel, wph ^ m_ph);
    if (rel) begin wph = ~wph; #1; chk("R2 reblock", rel, 1'b0); end
  endtask

  initial begin
    #(CLK_PERIOD * 30000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] n, left, ch;
    void'($urandom(32'h5eed_0042));
    #(CLK_PERIOD * 2 + 1ns);
    chk("R1 phase", phase, 1'b0); chk("R1 armed", armed, 1'b0);
    chk("R1 ovf", ovf, 1'b0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R9: unarmed report ignored, does not leak into the next round
    cyc(0, 0, 1, 20'd7, 0);
    cyc(1, 20'd10, 0, 0, 0);
    cyc(0, 0, 1, 20'd9, 0);     // R9 still pending at 9 of 10
    chk("R9 no flip", phase, 1'b0);
    cyc(0, 0, 1, 20'd1, 0);     // R4 exact hit
    // R5: report after a flip ignored until re-armed
    cyc(0, 0, 1, 20'd3, 0);
    // R8: arm and report same cycle
    cyc(1, 20'd4, 1, 20'd4, 0);
    // R10: re-arm keeps total
    cyc(1, 20'd8, 1, 20'd5, 0);
    cyc(1, 20'd6, 0, 0, 0);
    cyc(0, 0, 1, 20'd1, 0);
    // R7: commit unarmed, and commit with completing report
    cyc(0, 0, 0, 0, 1);
    cyc(1, 20'd2, 0, 0, 0);
    cyc(0, 0, 1, 20'd2, 1);
    chk("R7 single flip", armed, 1'b0);
    // R6 / R11: overshoot past 20-bit range
    cyc(1, 20'hFFFFF, 1, 20'hFFFF0, 0);
    cyc(0, 0, 1, 20'h00020, 0);
    chk("R11 ovf", ovf, 1'b1);
    cyc(1, 20'd3, 1, 20'd3, 0);
    chk("R6 sticky", ovf, 1'b1);

    // random rounds
    for (int rnd = 0; rnd < 300; rnd++) begin
      n = 20'($urandom_range(1, 4000));
      cyc(1, n, 0, 0, 0);
      left = n;
      while (left != 0) begin
        if ($urandom_range(0, 9) == 0) begin cyc(0, 0, 0, 0, 0); continue; end
        ch = 20'($urandom_range(1, 700));
        if (ch > left && $urandom_range(0, 7) != 0) ch = left;
        cyc(0, 0, 1, ch, 0);
        left = (ch >= left) ? '0 : left - ch;
      end
      if ($urandom_range(0, 15) == 0) cyc(0, 0, 0, 0, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule